// File: doc/BRIEF.md
# Three-Output Clock Post-Divider with Guarded Configuration

This block sits behind a PLL and turns its single fast oscillator-rate clock into three slower clocks, named R, Q and P. A 32-bit configuration word, written and read through a simple synchronous port, selects the division ratio of each output. It also switches the R and Q outputs on and off. All logic, including the configuration register, runs on the fast input clock.

Two inputs from the surrounding clock controller guard the configuration. `pll_on` reports that the PLL is running. While it is high, every ratio field keeps its value and writes to those fields are dropped. `r_is_sysclk` reports that the R output currently feeds the system clock. While it is high, the R enable bit cannot be changed. The Q enable bit can be written at any time. The P output has no enable and runs whenever the block is out of reset.

Each output is a registered flop output. An enable change is applied only between pulses, so every high pulse on an output has the full width for its ratio.

Top module: `pll_postdiv`

## Requirements
- R1: Synchronous active-high reset clears the configuration word to 0, holds R and Q low, and leaves P dividing by 7.
- R2: Field positions in the word are: P direct divisor in bits 31:27, R ratio code in bits 26:25, R enable in bit 24, Q ratio code in bits 22:21, Q enable in bit 20, and P 7/17 select in bit 17. Every other bit reads 0, and writing it has no effect (an all-ones write reads back 0xFF720000).
- R3: The R and Q ratio codes divide as follows: code 0 by 2, code 1 by 4, code 2 by 6 and code 3 by 8.
- R4: When the P direct divisor is 0, P divides by 7 if the select bit is 0 and by 17 if it is 1. A nonzero direct divisor sets the P ratio itself, with the value 1 treated as 2.
- R5: An output dividing by N is high for floor(N/2) input cycles and low for the remaining cycles of each period.
- R6: While `pll_on` is high, a write leaves the R code, Q code, P select and P direct fields unchanged. While `pll_on` is low, a write loads them.
- R7: While `r_is_sysclk` is high, a write leaves the R enable bit unchanged. The Q enable bit takes the written value whatever the state of the guard inputs.
- R8: An output whose enable bit is 0 stays low. An output whose enable bit is 1 carries its divided clock.
- R9: Turning an enable on or off never produces a shortened high pulse. Every high pulse has the full width given by R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock at the oscillator rate; clocks all logic |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writes `wr_data` into the configuration word on this edge |
| wr_data | input | 32 | Data for a configuration write |
| rd_data | output | 32 | Current configuration word |
| pll_on | input | 1 | PLL running; locks the ratio fields |
| r_is_sysclk | input | 1 | R output is the system clock; locks the R enable bit |
| clk_r_out | output | 1 | Divided clock R |
| clk_q_out | output | 1 | Divided clock Q |
| clk_p_out | output | 1 | Divided clock P |

## Verification
A wrong division counter or wrong ratio decode shows up as a wrong high or low width on the first complete pulse that follows a configuration change, which is within one period of at most 31 cycles. Gate logic that switches in mid-phase shows up as a short high pulse right after an enable write. A lock that leaks is visible in the read-back word on the cycle after the offending write. The bench measures every complete pulse width against widths it computes from the ratio rules, and it compares the read-back word after each write.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;

    localparam int REG_W     = 32;
    localparam int RATIO_W   = 5;
    localparam int CODE_W    = 2;
    localparam int NUM_OUT   = 3;

    localparam int P_DIR_LSB  = 27;
    localparam int R_CODE_LSB = 25;
    localparam int R_EN_BIT   = 24;
    localparam int Q_CODE_LSB = 21;
    localparam int Q_EN_BIT   = 20;
    localparam int P_SEL_BIT  = 17;

    localparam logic [RATIO_W-1:0] P_DIV_LO = RATIO_W'(7);
    localparam logic [RATIO_W-1:0] P_DIV_HI = RATIO_W'(17);
    localparam logic [RATIO_W-1:0] DIV_MIN  = RATIO_W'(2);

    typedef enum int {OUT_R = 0, OUT_Q = 1, OUT_P = 2} out_idx_e;

    typedef struct packed {
        logic [RATIO_W-1:0] p_dir;
        logic [CODE_W-1:0]  r_code;
        logic               r_en;
        logic [CODE_W-1:0]  q_code;
        logic               q_en;
        logic               p_sel;
    } cfg_t;

    function automatic cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        cfg_t c;
        c.p_dir  = w[P_DIR_LSB +: RATIO_W];
        c.r_code = w[R_CODE_LSB +: CODE_W];
        c.r_en   = w[R_EN_BIT];
        c.q_code = w[Q_CODE_LSB +: CODE_W];
        c.q_en   = w[Q_EN_BIT];
        c.p_sel  = w[P_SEL_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[P_DIR_LSB +: RATIO_W]  = c.p_dir;
        w[R_CODE_LSB +: CODE_W]  = c.r_code;
        w[R_EN_BIT]              = c.r_en;
        w[Q_CODE_LSB +: CODE_W]  = c.q_code;
        w[Q_EN_BIT]              = c.q_en;
        w[P_SEL_BIT]             = c.p_sel;
        return w;
    endfunction

    // Even ratio: (code + 1) * 2
    function automatic logic [RATIO_W-1:0] even_div(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] n;
        n = RATIO_W'(code) + RATIO_W'(1);
        return n << 1;
    endfunction

    function automatic logic [RATIO_W-1:0] p_div(input logic [RATIO_W-1:0] dir,
                                                 input logic sel);
        if (dir == '0)
            return sel ? P_DIV_HI : P_DIV_LO;
        else if (dir < DIV_MIN)
            return DIV_MIN;
        else
            return dir;
    endfunction

endpackage

// File: rtl/postdiv_cfg.sv
module postdiv_cfg
    import postdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pll_on,
    input  logic             r_is_sysclk,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rd_data
);

    cfg_t cfg_q;
    cfg_t cfg_d;
    cfg_t wr_cfg;

    assign wr_cfg = unpack_cfg(wr_data);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (!pll_on) begin
                cfg_d.r_code = wr_cfg.r_code;
                cfg_d.q_code = wr_cfg.q_code;
                cfg_d.p_sel  = wr_cfg.p_sel;
                cfg_d.p_dir  = wr_cfg.p_dir;
            end
            if (!r_is_sysclk)
                cfg_d.r_en = wr_cfg.r_en;
            cfg_d.q_en = wr_cfg.q_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else
            cfg_q <= cfg_d;
    end

    assign cfg     = cfg_q;
    assign rd_data = pack_cfg(cfg_q);

endmodule

// File: rtl/postdiv_div.sv
module postdiv_div #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ratio,
    input  logic             en,
    output logic             clk_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] half;
    logic             hi_phase;
    logic             gate;
    logic             restart;

    assign half     = ratio >> 1;
    assign hi_phase = (cnt < half);
    assign restart  = (ratio != ratio_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ratio_q <= '0;
            gate    <= 1'b0;
            clk_o   <= 1'b0;
        end else begin
            ratio_q <= ratio;
            if (restart || (cnt >= ratio - CNT_W'(1)))
                cnt <= '0;
            else
                cnt <= cnt + CNT_W'(1);
            // enable is sampled only inside the low phase
            if (!hi_phase)
                gate <= en;
            clk_o <= gate & hi_phase;
        end
    end

endmodule

// File: rtl/pll_postdiv.sv
module pll_postdiv
    import postdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             pll_on,
    input  logic             r_is_sysclk,
    output logic             clk_r_out,
    output logic             clk_q_out,
    output logic             clk_p_out
);

    cfg_t               cfg;
    logic [RATIO_W-1:0] ratio [NUM_OUT];
    logic [NUM_OUT-1:0] out_en;
    logic [NUM_OUT-1:0] div_out;

    postdiv_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .pll_on      (pll_on),
        .r_is_sysclk (r_is_sysclk),
        .cfg         (cfg),
        .rd_data     (rd_data)
    );

    assign ratio[OUT_R] = even_div(cfg.r_code);
    assign ratio[OUT_Q] = even_div(cfg.q_code);
    assign ratio[OUT_P] = p_div(cfg.p_dir, cfg.p_sel);

    assign out_en[OUT_R] = cfg.r_en;
    assign out_en[OUT_Q] = cfg.q_en;
    assign out_en[OUT_P] = 1'b1;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
        postdiv_div #(.CNT_W(RATIO_W)) u_div (
            .clk   (clk),
            .rst   (rst),
            .ratio (ratio[g]),
            .en    (out_en[g]),
            .clk_o (div_out[g])
        );
    end

    assign clk_r_out = div_out[OUT_R];
    assign clk_q_out = div_out[OUT_Q];
    assign clk_p_out = div_out[OUT_P];

endmodule

// File: rtl/pll_postdiv_chk.sv
module pll_postdiv_chk
    import postdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             pll_on,
    input logic             r_is_sysclk
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R6
    ratio_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pll_on) |=>
            (rd_data[R_CODE_LSB +: CODE_W] == $past(wr_data[R_CODE_LSB +: CODE_W])) &&
            (rd_data[Q_CODE_LSB +: CODE_W] == $past(wr_data[Q_CODE_LSB +: CODE_W])) &&
            (rd_data[P_DIR_LSB +: RATIO_W] == $past(wr_data[P_DIR_LSB +: RATIO_W])) &&
            (rd_data[P_SEL_BIT] == $past(wr_data[P_SEL_BIT])));

    // R6
    ratio_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pll_on) |=>
            $stable(rd_data[R_CODE_LSB +: CODE_W]) &&
            $stable(rd_data[Q_CODE_LSB +: CODE_W]) &&
            $stable(rd_data[P_DIR_LSB +: RATIO_W]) &&
            $stable(rd_data[P_SEL_BIT]));

    // R7
    ren_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && r_is_sysclk) |=> $stable(rd_data[R_EN_BIT]));

    // R7
    qen_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[Q_EN_BIT] == $past(wr_data[Q_EN_BIT])));

endmodule

bind pll_postdiv pll_postdiv_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .pll_on      (pll_on),
    .r_is_sysclk (r_is_sysclk)
);

// File: tb/pll_postdiv_bench.sv
module pll_postdiv_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pll_on = 1'b0;
    logic        r_is_sysclk = 1'b0;
    logic        clk_r_out, clk_q_out, clk_p_out;

    always #10 clk = ~clk;

    pll_postdiv u_pll_postdiv (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .pll_on      (pll_on),
        .r_is_sysclk (r_is_sysclk),
        .clk_r_out   (clk_r_out),
        .clk_q_out   (clk_q_out),
        .clk_p_out   (clk_p_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } pulse_t;

    pulse_t sbq0[$];
    pulse_t sbq1[$];
    pulse_t sbq2[$];

    bit    armed [3];
    bit    act   [3];
    bit    seen  [3];
    bit    pend  [3];
    bit    prev  [3];
    int    run   [3];
    int    elo   [3];
    string etag  [3];

    function automatic void check(bit ok, string tag, string what, longint a, longint e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, a, e);
        end
    endfunction

    function automatic int qsize(int c);
        case (c)
            0:       return sbq0.size();
            1:       return sbq1.size();
            default: return sbq2.size();
        endcase
    endfunction

    function automatic pulse_t pop_q(int c);
        case (c)
            0:       return sbq0.pop_front();
            1:       return sbq1.pop_front();
            default: return sbq2.pop_front();
        endcase
    endfunction

    // ratio rules computed from R3 / R4
    function automatic int code_div(int code);
        return 2 * (code + 1);
    endfunction

    // driver side of the scoreboard: expected pulse widths per R5
    task automatic expect_div(int c, int n_div, int cnt, string tag);
        pulse_t p;
        for (int i = 0; i < cnt; i++) begin
            p.hi  = n_div / 2;
            p.lo  = n_div - n_div / 2;
            p.tag = tag;
            case (c)
                0:       sbq0.push_back(p);
                1:       sbq1.push_back(p);
                default: sbq2.push_back(p);
            endcase
        end
    endtask

    task automatic flush(int c);
        case (c)
            0:       sbq0.delete();
            1:       sbq1.delete();
            default: sbq2.delete();
        endcase
    endtask

    // monitor side: measures widths and pops expectations
    always @(negedge clk) begin
        logic [2:0] s;
        pulse_t     p;
        s = {clk_p_out, clk_q_out, clk_r_out};
        for (int c = 0; c < 3; c++) begin
            if (!armed[c]) begin
                act[c]  = 0;
                pend[c] = 0;
            end else if (!act[c]) begin
                act[c]  = 1;
                seen[c] = 0;
                pend[c] = 0;
                prev[c] = s[c];
                run[c]  = 0;
            end else begin
                if (s[c] && !prev[c]) begin
                    if (pend[c]) begin
                        check(run[c] == elo[c], etag[c], "low width", run[c], elo[c]);
                        pend[c] = 0;
                    end
                    seen[c] = 1;
                    run[c]  = 1;
                end else if (!s[c] && prev[c]) begin
                    if (seen[c] && qsize(c) > 0) begin
                        p = pop_q(c);
                        check(run[c] == p.hi, p.tag, "high width", run[c], p.hi);
                        elo[c]  = p.lo;
                        etag[c] = p.tag;
                        pend[c] = 1;
                    end
                    run[c] = 1;
                end else begin
                    run[c]++;
                end
                prev[c] = s[c];
            end
        end
    end

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rdchk(logic [31:0] e, string tag);
        check(rd_data == e, tag, "readback", rd_data, e);
    endtask

    task automatic run_wait(string tag);
        int guard;
        guard = 0;
        for (int c = 0; c < 3; c++) armed[c] = (qsize(c) > 0);
        while (((qsize(0) + qsize(1) + qsize(2)) > 0 || pend[0] || pend[1] || pend[2])
               && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 4000)
            check(0, tag, "pulses missing", qsize(0) + qsize(1) + qsize(2), 0);
        for (int c = 0; c < 3; c++) begin
            armed[c] = 0;
            flush(c);
        end
        @(negedge clk);
    endtask

    task automatic check_low(int c, int cycles, string tag);
        int highs;
        logic [2:0] s;
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            s = {clk_p_out, clk_q_out, clk_r_out};
            if (s[c]) highs++;
        end
        check(highs == 0, tag, "cycles high on disabled output", highs, 0);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rdchk(32'h0000_0000, "R1");
        check_low(0, 40, "R1 R8 r");
        check_low(1, 40, "R1 R8 q");
        expect_div(2, 7, 3, "R1 R4 p7");
        run_wait("R1");

        // R2 R3 R4: R /4, Q /6, P /17
        wr(32'h0352_0000);
        rdchk(32'h0352_0000, "R2");
        settle();
        expect_div(0, code_div(1), 4, "R3 r4");
        expect_div(1, code_div(2), 4, "R3 q6");
        expect_div(2, 17, 3, "R4 p17");
        run_wait("R3");

        // R5 odd: R /8, Q /2, P direct 5
        wr(32'h2F10_0000);
        rdchk(32'h2F10_0000, "R2");
        settle();
        expect_div(0, code_div(3), 3, "R3 r8");
        expect_div(1, code_div(0), 6, "R3 q2");
        expect_div(2, 5, 4, "R5 p5");
        run_wait("R5");

        // R4: direct 1 behaves as 2
        wr(32'h0D10_0000);
        settle();
        expect_div(0, 6, 3, "R3 r6");
        expect_div(2, 2, 6, "R4 p1as2");
        run_wait("R4");

        // R4 R5: direct 31
        wr(32'hF910_0000);
        settle();
        expect_div(2, 31, 3, "R5 p31");
        expect_div(0, 2, 4, "R3 r2");
        run_wait("R5");

        // R2: reserved bits
        wr(32'hFFFF_FFFF);
        rdchk(32'hFF72_0000, "R2 reserved");
        settle();
        expect_div(0, 8, 3, "R2 r8");
        expect_div(1, 8, 3, "R2 q8");
        run_wait("R2");

        // R6: ratio lock while PLL runs
        pll_on = 1'b1;
        wr(32'h0110_0000);
        rdchk(32'hFF72_0000, "R6 lock");
        settle();
        expect_div(0, 8, 3, "R6 r8");
        expect_div(2, 31, 2, "R6 p31");
        run_wait("R6");

        // R7: Q enable writable while locked
        wr(32'h0100_0000);
        rdchk(32'hFF62_0000, "R7 qen");
        repeat (12) @(negedge clk);
        check_low(1, 40, "R8 q off");
        wr(32'h0110_0000);
        rdchk(32'hFF72_0000, "R7 qen on");

        // R7: R enable locked while R is the system clock
        pll_on      = 1'b0;
        r_is_sysclk = 1'b1;
        wr(32'h0010_0000);
        rdchk(32'h0110_0000, "R7 ren lock");
        settle();
        expect_div(0, 2, 5, "R7 r2 on");
        expect_div(2, 7, 2, "R6 p7");
        run_wait("R7");
        r_is_sysclk = 1'b0;

        // R8 R9: enable on at several phases, R /4
        for (int off = 0; off < 4; off++) begin
            wr(32'h0210_0000);
            rdchk(32'h0210_0000, "R8 ren off");
            repeat (10) @(negedge clk);
            check_low(0, 20, "R8 r off");
            expect_div(0, 4, 3, "R9 enable");
            armed[0] = 1;
            repeat (off) @(negedge clk);
            wr(32'h0310_0000);
            run_wait("R9");
        end

        // R9: enable off at several phases, Q /6
        wr(32'h0350_0000);
        settle();
        for (int off = 0; off < 5; off++) begin
            wr(32'h0350_0000);
            repeat (12) @(negedge clk);
            expect_div(1, 6, 40, "R9 disable");
            armed[1] = 1;
            repeat (7 + off) @(negedge clk);
            wr(32'h0340_0000);
            repeat (20) @(negedge clk);
            armed[1] = 0;
            flush(1);
            check_low(1, 20, "R8 q off");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule